// File: doc/BRIEF.md
# Descriptor Ring DMA Handshake Engine

This block is the device side of a packet DMA channel. The host keeps two descriptor rings in memory, one for transmit and one for receive. Each descriptor is a single 32-bit word, and ownership passes between host and device through that word only. The host queues transmit frames by marking descriptors device-owned and pulsing a wakeup input. The engine then walks the transmit ring, hands each descriptor's length to the MAC, and returns the descriptor by clearing its ownership bit. Receive frames arrive as a byte stream. The engine counts their bytes, including the four trailing check bytes, and writes the completed length into the current device-owned receive descriptor.

The engine reaches memory through one word-addressed request/response port, with one read outstanding at a time. A single state machine serialises all descriptor traffic. Its states are `ST_IDLE`, `ST_TX_FETCH`, `ST_TX_LOOK`, `ST_TX_XMIT`, `ST_TX_RETURN`, `ST_RX_FETCH`, `ST_RX_LOOK` and `ST_RX_FILL`. Its transitions are:
- IDLE→RX_FETCH when a finished frame waits.
- IDLE→TX_FETCH when a wakeup is pending and no finished frame waits.
- TX_FETCH→TX_LOOK on the next clock.
- TX_LOOK→TX_XMIT on a read response showing device ownership.
- TX_LOOK→IDLE on a read response showing host ownership, which ends the scan.
- TX_XMIT→TX_RETURN on `tx_done`.
- TX_RETURN→IDLE after the writeback.
- RX_FETCH→RX_LOOK on the next clock.
- RX_LOOK→RX_FILL on a read response showing device ownership.
- RX_LOOK→IDLE on a read response showing host ownership, which drops the frame.
- RX_FILL→IDLE after the writeback.

Top module: `desc_ring_engine`

## Requirements
- R1: Descriptor word layout: bit 31 is ownership (1 = device), bit 30 is start-of-packet, bit 29 is end-of-packet, bits 10:0 are the byte length. Every descriptor word the engine writes carries zero in bits 28:11.
- R2: After reset all outputs are low. Without a `tx_kick` pulse or a finished receive frame the engine issues no memory request.
- R3: For a device-owned transmit descriptor the engine holds `tx_req` with `tx_len` equal to the length field and `tx_slot` equal to the ring index until `tx_done`. It then writes the descriptor back with ownership cleared and start/end bits and length kept.
- R4: The transmit scan stops at the first host-owned descriptor. That descriptor is not written and the index does not move past it, so a later `tx_kick` rereads the same slot.
- R5: A descriptor's address is its ring base plus its index. Indices count up and wrap to 0 after `RING_DEPTH`-1.
- R6: A completed receive frame is written back as ownership 0, start and end set, and length equal to the number of bytes received including the 4 check bytes. The length saturates at 2047.
- R7: If the current receive descriptor is host-owned when a frame is handled, the frame is dropped. Nothing is written, the receive index is unchanged, and `rx_drop_sts` is set.
- R8: `tx_irq` and `rx_irq` each pulse for one cycle, in the cycle after a transmit or receive writeback, when their enable input is high. A low enable suppresses the pulse.
- R9: A finished receive frame is served before the next transmit descriptor fetch when both are waiting.
- R10: A frame that ends while an earlier finished frame is still waiting is dropped and sets `rx_drop_sts`. The status stays set until `rx_drop_clr`.
- R11: A descriptor read waits for `mem_rvalid` however many cycles it takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_ring_base | input | ADDR_W | Word address of transmit descriptor 0 |
| rx_ring_base | input | ADDR_W | Word address of receive descriptor 0 |
| tx_kick | input | 1 | Wakeup pulse that starts a transmit scan |
| tx_irq_en | input | 1 | Enables the transmit-done pulse |
| rx_irq_en | input | 1 | Enables the receive-done pulse |
| rx_drop_clr | input | 1 | Clears the drop status |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Descriptor word to write |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| tx_req | output | 1 | Frame offered to the MAC |
| tx_len | output | 11 | Length of the offered frame |
| tx_slot | output | IDX_W | Ring index of the offered frame |
| tx_done | input | 1 | MAC finished the offered frame |
| rx_valid | input | 1 | One received byte this cycle |
| rx_last | input | 1 | This byte ends the frame |
| tx_irq | output | 1 | Transmit-done pulse |
| rx_irq | output | 1 | Receive-done pulse |
| rx_drop_sts | output | 1 | Sticky receive-drop status |

## Verification
The transmit scan is exercised in four patterns:
- A short run that ends on a host-owned slot, with reserved bits set in one descriptor. This separates a correct stop and clean writeback from overrun or bit leakage.
- A resume from that slot after a second wakeup, with the transmit interrupt masked.
- A 30-entry run that crosses the ring end under longer read latency, which exposes wrap and wait faults.
- A run whose wakeup coincides with a receive frame end, where the order of the writebacks reveals the priority.

Receive is exercised with:
- Normal frames.
- A frame landing on a host-owned slot.
- Two frames back-to-back behind a slow read, which trigger the overrun drop.
- An oversize frame, which checks saturation.

A behavioural model predicts every write, every MAC offer and both interrupt lines on each clock.

// File: rtl/dre_pkg.sv
package dre_pkg;

    localparam int WORD_W  = 32;
    localparam int LEN_W   = 11;
    localparam int OWN_POS = 31;
    localparam int SOP_POS = 30;
    localparam int EOP_POS = 29;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_FETCH,
        ST_TX_LOOK,
        ST_TX_XMIT,
        ST_TX_RETURN,
        ST_RX_FETCH,
        ST_RX_LOOK,
        ST_RX_FILL
    } dre_state_t;

    // Build a descriptor word; reserved bits are always zero.
    function automatic logic [WORD_W-1:0] pack_desc(
        input logic             own,
        input logic             sop,
        input logic             eop,
        input logic [LEN_W-1:0] len
    );
        logic [WORD_W-1:0] w;
        w              = '0;
        w[OWN_POS]     = own;
        w[SOP_POS]     = sop;
        w[EOP_POS]     = eop;
        w[LEN_W-1:0]   = len;
        return w;
    endfunction

endpackage

// File: rtl/dre_ring_index.sv
module dre_ring_index #(
    parameter int DEPTH = 32,
    parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [IW-1:0] idx
);

    generate
        if ((1 << IW) == DEPTH) begin : g_pow2
            // Natural binary rollover equals the ring wrap.
            always_ff @(posedge clk) begin
                if (!rst_n)       idx <= '0;
                else if (advance) idx <= idx + 1'b1;
            end
        end else begin : g_cmp
            always_ff @(posedge clk) begin
                if (!rst_n)
                    idx <= '0;
                else if (advance)
                    idx <= (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/dre_rx_meter.sv
module dre_rx_meter #(
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_last,
    input  logic          take,
    output logic          pend,
    output logic [LW-1:0] pend_len,
    output logic          overrun
);

    logic [LW-1:0] cnt;
    logic [LW-1:0] fin_len;
    logic          frame_end;

    assign frame_end = rx_valid && rx_last;
    assign fin_len   = (cnt == '1) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            pend     <= 1'b0;
            pend_len <= '0;
            overrun  <= 1'b0;
        end else begin
            overrun <= 1'b0;
            if (rx_valid) begin
                if (rx_last)        cnt <= '0;
                else if (cnt != '1) cnt <= cnt + 1'b1;
            end
            if (frame_end) begin
                if (!pend || take) begin
                    pend     <= 1'b1;
                    pend_len <= fin_len;
                end else begin
                    overrun  <= 1'b1;
                end
            end else if (take) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine
    import dre_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int RING_DEPTH = 32,
    parameter int IDX_W      = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tx_ring_base,
    input  logic [ADDR_W-1:0] rx_ring_base,
    input  logic              tx_kick,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    input  logic              rx_drop_clr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_req,
    output logic [10:0]       tx_len,
    output logic [IDX_W-1:0]  tx_slot,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic              rx_last,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              rx_drop_sts
);

    dre_state_t state_q, state_d;

    logic [IDX_W-1:0] tx_idx, rx_idx;
    logic             tx_adv, rx_adv;
    logic             rx_pend, rx_take, rx_overrun;
    logic [LEN_W-1:0] rx_pend_len;
    logic             tx_pend_q;
    logic             tx_sop_q, tx_eop_q;
    logic [LEN_W-1:0] tx_len_q;
    logic             rd_own;
    logic             unused_rsvd;

    assign rd_own      = mem_rdata[OWN_POS];
    assign unused_rsvd = ^mem_rdata[EOP_POS-1:LEN_W];

    dre_ring_index #(.DEPTH(RING_DEPTH), .IW(IDX_W)) u_tx_idx (
        .clk(clk), .rst_n(rst_n), .advance(tx_adv), .idx(tx_idx)
    );

    dre_ring_index #(.DEPTH(RING_DEPTH), .IW(IDX_W)) u_rx_idx (
        .clk(clk), .rst_n(rst_n), .advance(rx_adv), .idx(rx_idx)
    );

    dre_rx_meter #(.LW(LEN_W)) u_meter (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_last(rx_last), .take(rx_take),
        .pend(rx_pend), .pend_len(rx_pend_len), .overrun(rx_overrun)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_pend)        state_d = ST_RX_FETCH;
                else if (tx_pend_q) state_d = ST_TX_FETCH;
            end
            ST_TX_FETCH:  state_d = ST_TX_LOOK;
            ST_TX_LOOK: begin
                if (mem_rvalid) state_d = rd_own ? ST_TX_XMIT : ST_IDLE;
            end
            ST_TX_XMIT: begin
                if (tx_done) state_d = ST_TX_RETURN;
            end
            ST_TX_RETURN: state_d = ST_IDLE;
            ST_RX_FETCH:  state_d = ST_RX_LOOK;
            ST_RX_LOOK: begin
                if (mem_rvalid) state_d = rd_own ? ST_RX_FILL : ST_IDLE;
            end
            ST_RX_FILL:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs of the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_req    = 1'b0;
        rx_take   = 1'b0;
        tx_adv    = 1'b0;
        rx_adv    = 1'b0;
        unique case (state_q)
            ST_TX_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = tx_ring_base + ADDR_W'(tx_idx);
            end
            ST_TX_XMIT: tx_req = 1'b1;
            ST_TX_RETURN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tx_ring_base + ADDR_W'(tx_idx);
                mem_wdata = pack_desc(1'b0, tx_sop_q, tx_eop_q, tx_len_q);
                tx_adv    = 1'b1;
            end
            ST_RX_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = rx_ring_base + ADDR_W'(rx_idx);
            end
            ST_RX_LOOK: rx_take = mem_rvalid && !rd_own;
            ST_RX_FILL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rx_ring_base + ADDR_W'(rx_idx);
                mem_wdata = pack_desc(1'b0, 1'b1, 1'b1, rx_pend_len);
                rx_take   = 1'b1;
                rx_adv    = 1'b1;
            end
            default: ;
        endcase
    end

    assign tx_len  = tx_len_q;
    assign tx_slot = tx_idx;

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_pend_q   <= 1'b0;
            tx_sop_q    <= 1'b0;
            tx_eop_q    <= 1'b0;
            tx_len_q    <= '0;
            tx_irq      <= 1'b0;
            rx_irq      <= 1'b0;
            rx_drop_sts <= 1'b0;
        end else begin
            if (tx_kick)
                tx_pend_q <= 1'b1;
            else if (state_q == ST_TX_LOOK && mem_rvalid && !rd_own)
                tx_pend_q <= 1'b0;

            if (state_q == ST_TX_LOOK && mem_rvalid) begin
                tx_sop_q <= mem_rdata[SOP_POS];
                tx_eop_q <= mem_rdata[EOP_POS];
                tx_len_q <= mem_rdata[LEN_W-1:0];
            end

            tx_irq <= (state_q == ST_TX_RETURN) && tx_irq_en;
            rx_irq <= (state_q == ST_RX_FILL) && rx_irq_en;

            if (rx_overrun || (state_q == ST_RX_LOOK && mem_rvalid && !rd_own))
                rx_drop_sts <= 1'b1;
            else if (rx_drop_clr)
                rx_drop_sts <= 1'b0;
        end
    end

endmodule

// File: rtl/dre_engine_chk.sv
module dre_engine_chk #(
    parameter int ADDR_W     = 16,
    parameter int RING_DEPTH = 32,
    parameter int IDX_W      = $clog2(RING_DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] tx_ring_base,
    input logic [ADDR_W-1:0] rx_ring_base,
    input logic              rx_drop_clr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              tx_req,
    input logic [10:0]       tx_len,
    input logic [IDX_W-1:0]  tx_slot,
    input logic              tx_done,
    input logic              tx_irq,
    input logic              rx_irq,
    input logic              rx_drop_sts
);

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[28:11] == '0));

    assert_wb_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    assert_offer_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done) |=> (tx_req && $stable(tx_len) && $stable(tx_slot)));

    assert_addr_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((ADDR_W'(mem_addr - tx_ring_base) < ADDR_W'(RING_DEPTH)) ||
                     (ADDR_W'(mem_addr - rx_ring_base) < ADDR_W'(RING_DEPTH))));

    assert_tx_irq_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(mem_req && mem_we));

    assert_rx_irq_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(mem_req && mem_we));

    assert_drop_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_drop_sts && !rx_drop_clr) |=> rx_drop_sts);

endmodule

bind desc_ring_engine dre_engine_chk #(
    .ADDR_W(ADDR_W), .RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/desc_ring_engine_tb.sv
module desc_ring_engine_tb;

    localparam int AW    = 16;
    localparam int DEPTH = 32;
    localparam int IW    = 5;
    localparam logic [AW-1:0] TXB = 16'h0040;
    localparam logic [AW-1:0] RXB = 16'h0080;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          tx_kick = 0, tx_irq_en = 0, rx_irq_en = 0, rx_drop_clr = 0;
    logic          mem_req, mem_we, mem_rvalid = 0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata = '0;
    logic          tx_req, tx_done = 0, rx_valid = 0, rx_last = 0;
    logic [10:0]   tx_len;
    logic [IW-1:0] tx_slot;
    logic          tx_irq, rx_irq, rx_drop_sts;

    desc_ring_engine #(.ADDR_W(AW), .RING_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_ring_base(TXB), .rx_ring_base(RXB),
        .tx_kick(tx_kick), .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
        .rx_drop_clr(rx_drop_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_req(tx_req), .tx_len(tx_len), .tx_slot(tx_slot), .tx_done(tx_done),
        .rx_valid(rx_valid), .rx_last(rx_last),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_drop_sts(rx_drop_sts)
    );

    // ---------------- reference model state ----------------
    logic [31:0] mem [0:255];
    int          n_cmp = 0, n_bad = 0;
    int          q_waddr[$];
    logic [31:0] q_wdata[$];
    string       q_wtag[$];
    int          q_len[$];
    int          q_slot[$];
    int          lat = 1, rd_wait = 0, mac_cnt = 0, req_seen = 0, cyc = 0;
    bit          mac_busy = 0, exp_txi = 0, exp_rxi = 0;
    logic [7:0]  rd_addr;
    int          wa, ml, ms;
    logic [31:0] wd;
    string       wt;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dsc(input bit own, input int len);
        logic [31:0] w;
        w = '0;
        w[31] = own; w[30] = 1'b1; w[29] = 1'b1;
        w[10:0] = 11'(len);
        return w;
    endfunction

    // Memory, MAC and interrupt model, compared every clock
    always @(negedge clk) begin
        if (rst_n) begin
            check(tx_irq == exp_txi, "R8", "tx_irq", tx_irq, exp_txi);
            check(rx_irq == exp_rxi, "R8", "rx_irq", rx_irq, exp_rxi);
            exp_txi = 0;
            exp_rxi = 0;
            mem_rvalid = 0;
            if (rd_wait > 0) begin
                rd_wait--;
                if (rd_wait == 0) begin
                    mem_rvalid = 1;
                    mem_rdata  = mem[rd_addr];
                end
            end
            if (mem_req) begin
                req_seen++;
                if (mem_we) begin
                    if (q_waddr.size() == 0) begin
                        check(0, "R4", "unexpected write addr", mem_addr, 0);
                    end else begin
                        wa = q_waddr.pop_front();
                        wd = q_wdata.pop_front();
                        wt = q_wtag.pop_front();
                        check(mem_addr == AW'(wa), wt, "write addr", mem_addr, wa);
                        check(mem_wdata == wd, wt, "write data", mem_wdata, wd);
                    end
                    mem[mem_addr[7:0]] = mem_wdata;
                    if (mem_addr >= TXB && mem_addr < TXB + AW'(DEPTH)) exp_txi = tx_irq_en;
                    else exp_rxi = rx_irq_en;
                end else begin
                    rd_addr = mem_addr[7:0];
                    rd_wait = lat;
                end
            end
            tx_done = 0;
            if (mac_busy) begin
                mac_cnt--;
                if (mac_cnt == 0) begin
                    tx_done  = 1;
                    mac_busy = 0;
                end
            end else if (tx_req) begin
                if (q_len.size() == 0) begin
                    check(0, "R4", "unexpected tx offer", tx_slot, 0);
                end else begin
                    ml = q_len.pop_front();
                    ms = q_slot.pop_front();
                    check(tx_len == 11'(ml), "R3", "tx_len", tx_len, ml);
                    check(tx_slot == IW'(ms), "R5", "tx_slot", tx_slot, ms);
                end
                mac_busy = 1;
                mac_cnt  = 3;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick();
        @(negedge clk); tx_kick = 1;
        @(negedge clk); tx_kick = 0;
    endtask

    task automatic frame(input int n, input bit keep, input bit kick_end);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1;
            rx_last  = (i == n - 1);
            if (i == n - 1 && kick_end) tx_kick = 1;
        end
        if (!keep) begin
            @(negedge clk);
            rx_valid = 0; rx_last = 0; tx_kick = 0;
        end
    endtask

    task automatic exp_tx(input int slot, input int len, input string tag);
        q_len.push_back(len);
        q_slot.push_back(slot);
        q_waddr.push_back(int'(TXB) + slot);
        q_wdata.push_back(dsc(0, len));
        q_wtag.push_back(tag);
    endtask

    task automatic exp_rx(input int slot, input int len, input string tag);
        q_waddr.push_back(int'(RXB) + slot);
        q_wdata.push_back(dsc(0, len));
        q_wtag.push_back(tag);
    endtask

    task automatic drained(input string tag);
        check(q_waddr.size() == 0, tag, "writes outstanding", q_waddr.size(), 0);
        check(q_len.size() == 0, tag, "offers outstanding", q_len.size(), 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        tick(5);
        rst_n = 1;
        tick(1);
        // R2: reset state and quiet without work
        check(mem_req == 0, "R2", "mem_req", mem_req, 0);
        check(tx_req == 0, "R2", "tx_req", tx_req, 0);
        check(rx_drop_sts == 0, "R2", "rx_drop_sts", rx_drop_sts, 0);
        tick(10);
        check(req_seen == 0, "R2", "requests while idle", req_seen, 0);

        // S1: three frames, stop on host-owned slot 3; reserved bits in slot 0 (R1)
        tx_irq_en = 1;
        mem[TXB + 0] = dsc(1, 60) | 32'h00AA_A800;
        mem[TXB + 1] = dsc(1, 1514);
        mem[TXB + 2] = dsc(1, 64);
        mem[TXB + 3] = 32'h0000_0020;
        exp_tx(0, 60, "R1");
        exp_tx(1, 1514, "R3");
        exp_tx(2, 64, "R3");
        kick();
        tick(80);
        drained("R4");
        check(mem[TXB + 3] == 32'h0000_0020, "R4", "stop slot untouched", mem[TXB + 3], 32'h20);

        // S2: resume at slot 3 with transmit interrupt masked
        tx_irq_en = 0;
        mem[TXB + 3] = dsc(1, 100);
        exp_tx(3, 100, "R4");
        kick();
        tick(40);
        drained("R4");

        // S3: 30 frames across the ring end, slower reads (R5, R11)
        lat = 3;
        tx_irq_en = 1;
        for (int s = 4; s < 32; s++) begin
            mem[TXB + s] = dsc(1, 100 + s);
            exp_tx(s, 100 + s, "R5");
        end
        for (int s = 0; s < 2; s++) begin
            mem[TXB + s] = dsc(1, 200 + s);
            exp_tx(s, 200 + s, "R5");
        end
        kick();
        tick(700);
        drained("R5");

        // S4: receive frames into device-owned slots
        lat = 1;
        rx_irq_en = 1;
        mem[RXB + 0] = dsc(1, 1536);
        mem[RXB + 1] = dsc(1, 1536);
        exp_rx(0, 64, "R6");
        frame(64, 0, 0);
        tick(20);
        exp_rx(1, 7, "R6");
        frame(7, 0, 0);
        tick(20);
        drained("R6");

        // S5: host-owned receive slot drops the frame, index holds (R7)
        mem[RXB + 2] = '0;
        frame(50, 0, 0);
        tick(20);
        drained("R7");
        check(rx_drop_sts == 1, "R7", "drop status", rx_drop_sts, 1);
        check(mem[RXB + 2] == 0, "R7", "host slot untouched", mem[RXB + 2], 0);
        @(negedge clk); rx_drop_clr = 1;
        @(negedge clk); rx_drop_clr = 0;
        check(rx_drop_sts == 0, "R10", "drop status cleared", rx_drop_sts, 0);
        mem[RXB + 2] = dsc(1, 1536);
        exp_rx(2, 30, "R7");
        frame(30, 0, 0);
        tick(20);
        drained("R7");

        // S6: second frame ends behind a slow read of the first (R10, R11)
        lat = 20;
        mem[RXB + 3] = dsc(1, 1536);
        exp_rx(3, 10, "R11");
        frame(10, 1, 0);
        frame(5, 0, 0);
        tick(60);
        drained("R10");
        check(rx_drop_sts == 1, "R10", "overrun drop status", rx_drop_sts, 1);
        tick(5);
        check(rx_drop_sts == 1, "R10", "drop status held", rx_drop_sts, 1);
        @(negedge clk); rx_drop_clr = 1;
        @(negedge clk); rx_drop_clr = 0;

        // S7: frame end and wakeup in the same cycle, receive first (R9)
        lat = 2;
        mem[RXB + 4] = dsc(1, 1536);
        mem[TXB + 2] = dsc(1, 200);
        exp_rx(4, 5, "R9");
        exp_tx(2, 200, "R9");
        frame(5, 0, 1);
        tick(60);
        drained("R9");

        // S8: oversize frame saturates, receive interrupt masked (R6, R8)
        lat = 1;
        rx_irq_en = 0;
        mem[RXB + 5] = dsc(1, 1536);
        exp_rx(5, 2047, "R6");
        frame(2100, 0, 0);
        tick(30);
        drained("R6");

        summary();
    end

endmodule